// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register with Gated Clock

This block is an eight-stage shift register with two ways to fill it. While the active-low load pin is asserted, every stage tracks its parallel data pin. While the load pin is released, the register moves one position toward the serial output on each qualifying clock event. The last stage drives a serial output, and a second output carries the inverse of that bit.

Shift events come from two pins that are treated the same way. A rising transition on either pin moves the register by one position, but only while the other pin is low. The pins therefore act as a NOR-gated clock: one of them can be the shift clock and the other an inhibit, in either assignment. A pin held high blocks every edge on its partner.

All pins are external and asynchronous to the system clock. Each one passes through a two-flop synchronizer, and the block finds edges itself in the system clock domain. A one-cycle strobe marks each accepted shift. All stages are also driven out in parallel, so the surrounding logic can observe the contents.

Top module: `piso_shift8`

## Requirements
- R1: `ser_out` always equals stage H (`stages[7]`), and `ser_out_n` always equals its inverse.
- R2: While the synchronized `load_n` is low, all stages follow `par_in` on every cycle (`stages[0]` is stage A, `stages[7]` is stage H), whatever the two clock pins do.
- R3: With `load_n` high, a rising edge on `ext_clk` while `ext_inh` is low shifts the register by exactly one position.
- R4: With `load_n` high, a rising edge on `ext_inh` while `ext_clk` is low also shifts the register by exactly one position.
- R5: On a shift, stage A takes `ser_in`, and each of the other stages takes the previous value of the stage below it.
- R6: While either clock pin is held high, edges on the other pin cause no shift, and the stages keep their value.
- R7: With `load_n` high and no qualifying edge, the stages hold their value.
- R8: `shift_strobe` is high for exactly one cycle per accepted shift, in the cycle the shifted value first appears. It is low in every other cycle.
- R9: A synchronous active-low `rst_n` clears all stages and `shift_strobe` to zero.
- R10: A pin change applied in cycle n shows up on `stages` and `shift_strobe` in cycle n+3 (two synchronizer flops plus the stage register).
- R11: When a load and a qualifying edge reach the logic in the same cycle, the load wins and no strobe is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_clk | input | 1 | Gated clock pin, asynchronous |
| ext_inh | input | 1 | Second gated clock pin (inhibit role), asynchronous |
| load_n | input | 1 | Active-low parallel load, level-sensitive |
| ser_in | input | 1 | Serial data shifted into stage A |
| par_in | input | 8 | Parallel data; bit 0 is stage A, bit 7 is stage H |
| ser_out | output | 1 | Stage H |
| ser_out_n | output | 1 | Inverse of stage H |
| shift_strobe | output | 1 | One-cycle pulse per accepted shift |
| stages | output | 8 | Read-back of all stages |

## Verification
Every stage value and every strobe is due three system cycles after the pin change that causes it. The driver task drives pins just after a rising edge and pushes each expected item tagged with that due cycle. The monitor samples on the falling edge and pops an item only when the cycle counter reaches its due cycle. For each shift, the driver also queues strobe-low items for the following cycles, which verifies the single-cycle pulse and the hold behaviour. The monitor checks the pairing of the two serial outputs on every cycle.

// File: rtl/piso_shift8.sv
module piso_shift8 #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_clk,
  input  logic             ext_inh,
  input  logic             load_n,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_in,
  output logic             ser_out,
  output logic             ser_out_n,
  output logic             shift_strobe,
  output logic [WIDTH-1:0] stages
);
  localparam int NB = WIDTH + 4;
  localparam logic [NB-1:0] SYNC_RST = NB'(4);

  logic [NB-1:0] sync_q [SYNC_STAGES];
  logic [NB-1:0] raw, s;
  logic clk_s, inh_s, ld_n_s, ser_s, gate_prev, shift_evt;
  logic [WIDTH-1:0] par_s;

  assign raw = {par_in, ser_in, load_n, ext_inh, ext_clk};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= SYNC_RST;
    end else begin
      sync_q[0] <= raw;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign s      = sync_q[SYNC_STAGES-1];
  assign clk_s  = s[0];
  assign inh_s  = s[1];
  assign ld_n_s = s[2];
  assign ser_s  = s[3];
  assign par_s  = s[NB-1:4];

  assign shift_evt = (clk_s | inh_s) & ~gate_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gate_prev    <= 1'b0;
      stages       <= '0;
      shift_strobe <= 1'b0;
    end else begin
      gate_prev    <= clk_s | inh_s;
      shift_strobe <= shift_evt & ld_n_s;
      if (!ld_n_s)        stages <= par_s;
      else if (shift_evt) stages <= {stages[WIDTH-2:0], ser_s};
    end
  end

  assign ser_out   = stages[WIDTH-1];
  assign ser_out_n = ~stages[WIDTH-1];

  p_load_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(ld_n_s) |-> stages == $past(par_s) && !shift_strobe);

  p_shift_dir_r5: assert property (@(posedge clk) disable iff (!rst_n)
    shift_strobe |-> stages[WIDTH-1:1] == $past(stages[WIDTH-2:0]));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(ld_n_s) && !shift_strobe |-> $stable(stages));

  p_clk_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(clk_s) && clk_s |=> !shift_strobe);

  p_inh_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(inh_s) && inh_s |=> !shift_strobe);

  p_strobe_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    shift_strobe |=> !shift_strobe);
endmodule

// File: tb/test_piso_shift8.sv
module test_piso_shift8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ext_clk = 1'b0, ext_inh = 1'b0, load_n = 1'b1, ser_in = 1'b0;
  logic [7:0] par_in = 8'h00;
  logic ser_out, ser_out_n, shift_strobe;
  logic [7:0] stages;

  piso_shift8 i_piso_shift8 (.clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .ext_inh(ext_inh),
    .load_n(load_n), .ser_in(ser_in), .par_in(par_in), .ser_out(ser_out),
    .ser_out_n(ser_out_n), .shift_strobe(shift_strobe), .stages(stages));

  always #5 clk = ~clk;

  typedef struct { int due; logic [7:0] val; logic st; string rq; } item_t;
  item_t q[$];
  int cyc = 0, checks = 0, errors = 0;
  logic [7:0] exp_v = 8'h00;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic push(int due, logic [7:0] v, logic st, string rq);
    item_t it;
    it.due = due; it.val = v; it.st = st; it.rq = rq;
    q.push_back(it);
  endtask

  task automatic idle(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic load_byte(logic [7:0] b);
    load_n = 1'b0; par_in = b; exp_v = b;
    push(cyc + 3, b, 1'b0, "R2");
    idle(1);
    load_n = 1'b1;
    idle(1);
    push(cyc + 3, b, 1'b0, "R7");
    idle(4);
  endtask

  task automatic shift_one(bit use_inh, logic sb);
    ser_in = sb;
    if (use_inh) ext_inh = 1'b1; else ext_clk = 1'b1;
    exp_v = {exp_v[6:0], sb};
    push(cyc + 3, exp_v, 1'b1, use_inh ? "R4" : "R3");
    idle(1);
    push(cyc + 3, exp_v, 1'b0, "R8");
    if (use_inh) ext_inh = 1'b0; else ext_clk = 1'b0;
    idle(1);
    push(cyc + 3, exp_v, 1'b0, "R7");
    idle(3);
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (ser_out_n !== ~ser_out) begin
        errors++;
        $display("FAIL R1 pair: ser_out=%b ser_out_n=%b expected inverse", ser_out, ser_out_n);
      end
      while (q.size() > 0 && q[0].due <= cyc) begin
        item_t it;
        it = q.pop_front();
        checks++;
        if (it.due != cyc || stages !== it.val || shift_strobe !== it.st || ser_out !== it.val[7]) begin
          errors++;
          $display("FAIL %s cyc=%0d due=%0d: stages=%h strobe=%b ser_out=%b expected stages=%h strobe=%b ser_out=%b",
                   it.rq, cyc, it.due, stages, shift_strobe, ser_out, it.val, it.st, it.val[7]);
        end
      end
    end
  end

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: run hung, actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    join_none
    par_in = 8'hFF;
    idle(5);
    @(negedge clk);
    checks++;
    if (stages !== 8'h00 || shift_strobe !== 1'b0 || ser_out_n !== 1'b1) begin
      errors++;
      $display("FAIL R9: stages=%h strobe=%b ser_out_n=%b expected 00 0 1", stages, shift_strobe, ser_out_n);
    end
    par_in = 8'h00;
    @(posedge clk); #1;
    rst_n = 1'b1;
    idle(6);

    // R10 latency and R3/R5 shift via clock pin, inhibit low
    load_byte(8'hA5);
    for (int i = 0; i < 4; i++) shift_one(1'b0, i[0]);
    // R4: inhibit pin acting as the clock
    load_byte(8'h3C);
    for (int i = 0; i < 4; i++) shift_one(1'b1, ~i[0]);

    // R6: inhibit held high blocks clock edges (raising it is itself a shift)
    load_byte(8'h81);
    ser_in = 1'b1; ext_inh = 1'b1; exp_v = {exp_v[6:0], 1'b1};
    push(cyc + 3, exp_v, 1'b1, "R4");
    idle(5);
    for (int i = 0; i < 3; i++) begin
      ser_in = i[0];
      ext_clk = 1'b1;
      push(cyc + 3, exp_v, 1'b0, "R6");
      idle(2);
      ext_clk = 1'b0;
      push(cyc + 3, exp_v, 1'b0, "R6");
      idle(2);
    end
    ext_inh = 1'b0;
    push(cyc + 3, exp_v, 1'b0, "R6");
    idle(5);

    // R6: clock held high blocks inhibit-pin edges
    ser_in = 1'b0; ext_clk = 1'b1; exp_v = {exp_v[6:0], 1'b0};
    push(cyc + 3, exp_v, 1'b1, "R3");
    idle(5);
    for (int i = 0; i < 3; i++) begin
      ext_inh = 1'b1;
      push(cyc + 3, exp_v, 1'b0, "R6");
      idle(2);
      ext_inh = 1'b0;
      idle(2);
    end
    ext_clk = 1'b0;
    idle(5);

    // R2: load follows parallel pins continuously, clock pins ignored
    load_n = 1'b0;
    for (int i = 0; i < 4; i++) begin
      par_in = 8'h11 * (i + 1);
      ext_clk = i[0];
      exp_v = par_in;
      push(cyc + 3, exp_v, 1'b0, "R2");
      idle(2);
    end
    ext_clk = 1'b0;
    idle(3);
    load_n = 1'b1;
    idle(5);

    // R11: load and clock edge arrive together
    load_n = 1'b0; par_in = 8'h5A; ext_clk = 1'b1; exp_v = 8'h5A;
    push(cyc + 3, exp_v, 1'b0, "R11");
    idle(1);
    push(cyc + 3, exp_v, 1'b0, "R11");
    load_n = 1'b1;
    idle(2);
    ext_clk = 1'b0;
    idle(5);
    // shift out the full byte after it
    for (int i = 0; i < 8; i++) shift_one(i[1], 1'b0);
    push(cyc + 3, 8'h00, 1'b0, "R5");
    idle(8);

    done = 1;
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R10: %0d items never reached their due cycle, expected 0", q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule